// File: doc/BRIEF.md
# Accumulator Row Group Index Sequencer

This block produces the index stream for one multi-vector dot-product-accumulate operation. A single start pulse carries the operation's parameters: a group count of two or four, a 32-bit vector-select base, a 3-bit offset, a 5-bit first-source register number and a 4-bit second-source register number. From the following cycle the block emits one index triple per clock: a first-source register index, a second-source register index and an accumulator row index. A valid strobe marks each triple, and a done flag marks the last one.

The accumulator array has as many rows as the vector length in bits divided by 8. The array is split into as many equal sections as there are groups. The width of one section is the row stride. The first row is the sum of the base and the offset, reduced modulo the stride. Each later step adds one stride, so every step lands in a different section. The first-source index counts upward modulo 32, and the second-source index stays the same for the whole operation.

The block does no arithmetic on vector data and touches no register file. A datapath consumes the triples as they appear.

Top module: `zaseq_top`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, out_valid, out_done, out_row, out_src1 and out_src2 are all zero.
- R2: A start accepted at a clock edge makes out_valid high from that edge onward for exactly N consecutive cycles. N is 2 when grp4 is 0 and 4 when grp4 is 1. The first triple appears in the cycle right after the accepting edge.
- R3: The row count is VL_BITS/8 and the stride is that count divided by N. On step r (counting from 0) out_row equals the first row plus r times the stride.
- R4: The first row equals (vsel_base + vsel_off) modulo the stride. vsel_base is an unsigned 32-bit value and vsel_off is an unsigned value from 0 to 7.
- R5: On step r, out_src1 equals (src1_in + r) modulo 32, so 31 is followed by 0.
- R6: out_src2 equals the src2_in value captured at start, on every step of the operation.
- R7: out_done is high for exactly one cycle per operation. That cycle is the one that carries the final triple, and out_done is never high without out_valid.
- R8: A start seen while out_valid is high is ignored. This includes the cycle in which out_done is high. The running sequence is unaffected, and out_valid is low in the cycle after out_done.
- R9: All operation inputs are captured at the accepting edge. Changing them after that edge does not alter any triple of the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin an operation; honoured only while out_valid is low |
| grp4 | input | 1 | Group count select: 0 gives two steps, 1 gives four steps |
| vsel_base | input | 32 | Unsigned vector-select base value |
| vsel_off | input | 3 | Unsigned vector-select offset, 0 to 7 |
| src1_in | input | 5 | First-source register number |
| src2_in | input | 4 | Second-source register number, 0 to 15 |
| out_valid | output | 1 | A valid index triple is presented |
| out_done | output | 1 | The presented triple is the last of the operation |
| out_src1 | output | 5 | First-source register index for this step |
| out_src2 | output | 4 | Second-source register index |
| out_row | output | $clog2(VL_BITS/8) | Accumulator row index for this step |

## Verification
Two situations are hard to reach from the ports. The first is a start request that coincides with the done cycle, which must be dropped even though the operation is already finishing. The bench reaches it with a disturbance mode that holds start high, with scrambled operand inputs, through every step of an operation, including the done cycle. It then checks that out_valid falls in the following cycle. The second is the carry out of the 32-bit sum of base and offset, which must not disturb the masked first row. Directed cases with an all-ones base and the largest offset reach it, and random bases cover the rest.

// File: rtl/zaseq_pkg.sv
// Package: zaseq_pkg
// Shared widths and types for the accumulator row group index sequencer.
// Assumes the operand register fields keep their fixed widths on every use.
package zaseq_pkg;
    localparam int BASE_W = 32;
    localparam int OFF_W  = 3;
    localparam int SRC1_W = 5;
    localparam int SRC2_W = 4;
    localparam int STEP_W = 2;

    typedef logic [BASE_W-1:0] base_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [SRC1_W-1:0] src1_t;
    typedef logic [SRC2_W-1:0] src2_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/zaseq_row_calc.sv
// Module: zaseq_row_calc
// Works out the first accumulator row and the row stride for the chosen group count.
// Assumes ROWS is a power of two and at least 4, so every stride is a power of two
// and the modulo becomes a mask of the low bits.
module zaseq_row_calc
    import zaseq_pkg::*;
#(
    parameter int ROWS  = 64,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             grp4,
    input  base_t            base,
    input  off_t             off,
    output logic [ROW_W-1:0] first_row,
    output logic [ROW_W-1:0] stride
);
    localparam logic [ROW_W-1:0] STRIDE2 = ROW_W'(ROWS / 2);
    localparam logic [ROW_W-1:0] STRIDE4 = ROW_W'(ROWS / 4);

    base_t            sum;
    logic [ROW_W-1:0] mask;

    // Pick the stride, add base and offset, then reduce by masking.
    always_comb begin
        stride    = grp4 ? STRIDE4 : STRIDE2;
        mask      = stride - ROW_W'(1);
        sum       = base + base_t'(off);
        first_row = sum[ROW_W-1:0] & mask;
    end
endmodule

// File: rtl/zaseq_ctrl.sv
// Module: zaseq_ctrl
// Step controller: accepts a start only while idle and counts the steps of the
// operation. It flags the final step.
// Assumes the group count is two or four, so at most four steps are needed.
module zaseq_ctrl
    import zaseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic grp4,
    output logic accept,
    output logic advance,
    output logic valid,
    output logic last
);
    seq_state_t state;
    step_t      step;
    step_t      last_step;

    // Accept a request only when no triple is being presented.
    always_comb begin
        accept  = start && (state == ST_IDLE);
        valid   = (state == ST_RUN);
        last    = valid && (step == last_step);
        advance = valid && !last;
    end

    // Step counter and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            step      <= '0;
            last_step <= '0;
        end else if (accept) begin
            state     <= ST_RUN;
            step      <= '0;
            last_step <= grp4 ? step_t'(3) : step_t'(1);
        end else if (last) begin
            state <= ST_IDLE;
            step  <= '0;
        end else if (valid) begin
            step <= step + step_t'(1);
        end
    end
endmodule

// File: rtl/zaseq_idx.sv
// Module: zaseq_idx
// Index registers: load the first triple on accept, then step the row by the
// stride and the first-source index by one on each advance.
// Assumes load and advance are never high together.
module zaseq_idx
    import zaseq_pkg::*;
#(
    parameter int ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [ROW_W-1:0] first_row,
    input  logic [ROW_W-1:0] stride,
    input  src1_t            src1_in,
    input  src2_t            src2_in,
    output logic [ROW_W-1:0] row,
    output src1_t            src1,
    output src2_t            src2
);
    logic [ROW_W-1:0] stride_q;

    // Capture on load, step on advance; the 5-bit add wraps modulo 32.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row      <= '0;
            stride_q <= '0;
            src1     <= '0;
            src2     <= '0;
        end else if (load) begin
            row      <= first_row;
            stride_q <= stride;
            src1     <= src1_in;
            src2     <= src2_in;
        end else if (advance) begin
            row  <= row + stride_q;
            src1 <= src1 + src1_t'(1);
        end
    end
endmodule

// File: rtl/zaseq_top.sv
// Module: zaseq_top
// Accumulator row group index sequencer. After an accepted start it emits one
// index triple per cycle, two or four in all, and marks the last with out_done.
// Assumes VL_BITS is a power of two of at least 32, so there are at least 4 rows.
module zaseq_top
    import zaseq_pkg::*;
#(
    parameter int VL_BITS = 512,
    localparam int ROWS   = VL_BITS / 8,
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             grp4,
    input  logic [31:0]      vsel_base,
    input  logic [2:0]       vsel_off,
    input  logic [4:0]       src1_in,
    input  logic [3:0]       src2_in,
    output logic             out_valid,
    output logic             out_done,
    output logic [4:0]       out_src1,
    output logic [3:0]       out_src2,
    output logic [ROW_W-1:0] out_row
);
    logic             accept;
    logic             advance;
    logic [ROW_W-1:0] first_row;
    logic [ROW_W-1:0] stride;

    zaseq_row_calc #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row_calc (
        .grp4      (grp4),
        .base      (vsel_base),
        .off       (vsel_off),
        .first_row (first_row),
        .stride    (stride)
    );

    zaseq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .grp4    (grp4),
        .accept  (accept),
        .advance (advance),
        .valid   (out_valid),
        .last    (out_done)
    );

    zaseq_idx #(.ROW_W(ROW_W)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .advance   (advance),
        .first_row (first_row),
        .stride    (stride),
        .src1_in   (src1_in),
        .src2_in   (src2_in),
        .row       (out_row),
        .src1      (out_src1),
        .src2      (out_src2)
    );
endmodule

// File: rtl/zaseq_top_chk.sv
// Module: zaseq_top_chk
// Protocol checker for zaseq_top, attached with bind. Observes ports only.
module zaseq_top_chk #(
    parameter int VL_BITS = 512,
    localparam int ROWS   = VL_BITS / 8,
    localparam int ROW_W  = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [4:0]       src1_in,
    input logic             out_valid,
    input logic             out_done,
    input logic [4:0]       out_src1,
    input logic [3:0]       out_src2,
    input logic [ROW_W-1:0] out_row
);
    localparam logic [ROW_W-1:0] HALF  = ROW_W'(ROWS / 2);
    localparam logic [ROW_W-1:0] QUART = ROW_W'(ROWS / 4);

    // R7: done only travels with a valid triple
    a_r7_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_valid);

    // R8: the presentation ends right after done
    a_r8_drop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_valid);

    // R2: an accepted start produces a first, non-final triple
    a_r2_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !out_valid) |=> (out_valid && !out_done));

    // R5: the first triple carries the captured first-source number
    a_r5_first_src1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !out_valid) |=> (out_src1 == $past(src1_in)));

    // R5: consecutive steps advance the first-source index by one, wrapping
    a_r5_src1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_src1 == 5'($past(out_src1) + 5'd1)));

    // R6: second-source index is held across the operation
    a_r6_src2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(out_src2));

    // R3: consecutive rows differ by one of the two legal strides
    a_r3_row_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |->
        ((ROW_W'(out_row - $past(out_row)) == HALF) || (ROW_W'(out_row - $past(out_row)) == QUART)));

    // R4: the first row lies inside the first section
    a_r4_first_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_row < HALF));
endmodule

bind zaseq_top zaseq_top_chk #(.VL_BITS(VL_BITS)) u_zaseq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src1_in   (src1_in),
    .out_valid (out_valid),
    .out_done  (out_done),
    .out_src1  (out_src1),
    .out_src2  (out_src2),
    .out_row   (out_row)
);

// File: tb/zaseq_top_test.sv
// Bench for zaseq_top: directed corners plus seeded random operations.
module zaseq_top_test;
    localparam int VL_BITS = 512;
    localparam int ROWS    = VL_BITS / 8;
    localparam int ROW_W   = $clog2(ROWS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             grp4 = 1'b0;
    logic [31:0]      vsel_base = '0;
    logic [2:0]       vsel_off = '0;
    logic [4:0]       src1_in = '0;
    logic [3:0]       src2_in = '0;
    logic             out_valid;
    logic             out_done;
    logic [4:0]       out_src1;
    logic [3:0]       out_src2;
    logic [ROW_W-1:0] out_row;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    int unsigned seed_val;

    always #2 clk = ~clk;

    zaseq_top #(.VL_BITS(VL_BITS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .grp4(grp4),
        .vsel_base(vsel_base), .vsel_off(vsel_off),
        .src1_in(src1_in), .src2_in(src2_in),
        .out_valid(out_valid), .out_done(out_done),
        .out_src1(out_src1), .out_src2(out_src2), .out_row(out_row)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_stride(input bit g4);
        return g4 ? ROWS / 4 : ROWS / 2;
    endfunction

    function automatic int exp_row(input bit g4, input logic [31:0] b, input logic [2:0] o, input int r);
        longint unsigned s;
        s = longint'(b) + longint'(o);
        return int'(s % longint'(exp_stride(g4))) + r * exp_stride(g4);
    endfunction

    task automatic scramble();
        grp4      = 1'($urandom);
        vsel_base = $urandom;
        vsel_off  = 3'($urandom);
        src1_in   = 5'($urandom);
        src2_in   = 4'($urandom);
    endtask

    // One operation; disturb keeps start high with scrambled inputs throughout (R8).
    task automatic run_op(input bit g4, input logic [31:0] b, input logic [2:0] o,
                          input logic [4:0] s1, input logic [3:0] s2, input bit disturb);
        int n;
        n = g4 ? 4 : 2;
        @(negedge clk);
        grp4 = g4; vsel_base = b; vsel_off = o; src1_in = s1; src2_in = s2;
        start = 1'b1;
        for (int r = 0; r < n; r++) begin
            @(negedge clk);
            start = disturb;
            scramble();   // R9: inputs change after the accepting edge
            chk("R2 valid", 32'(out_valid), 32'd1);
            chk("R7 done", 32'(out_done), 32'(r == n - 1));
            chk("R3 R4 row", 32'(out_row), 32'(exp_row(g4, b, o, r)));
            chk("R5 src1", 32'(out_src1), 32'((int'(s1) + r) % 32));
            chk("R6 src2", 32'(out_src2), 32'(s2));
        end
        @(negedge clk);
        chk("R8 R2 idle after done", 32'(out_valid), 32'd0);
        chk("R7 done low after", 32'(out_done), 32'd0);
        start = 1'b0;
    endtask

    initial begin
        seed_val = $urandom(32'd20240611);
        start = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 valid in reset", 32'(out_valid), 32'd0);
        chk("R1 done in reset", 32'(out_done), 32'd0);
        chk("R1 row in reset", 32'(out_row), 32'd0);
        chk("R1 src1 in reset", 32'(out_src1), 32'd0);
        chk("R1 src2 in reset", 32'(out_src2), 32'd0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 32'(out_valid), 32'd0);

        run_op(1'b0, 32'h0000_0000, 3'd0, 5'd0,  4'd0,  1'b0);
        run_op(1'b1, 32'hFFFF_FFFF, 3'd7, 5'd31, 4'd15, 1'b0);
        run_op(1'b0, 32'hFFFF_FFFF, 3'd7, 5'd31, 4'd15, 1'b1);
        run_op(1'b1, 32'h0000_000F, 3'd1, 5'd30, 4'd9,  1'b1);
        run_op(1'b1, 32'h8000_0010, 3'd0, 5'd29, 4'd3,  1'b0);
        run_op(1'b0, 32'h0000_001F, 3'd5, 5'd1,  4'd8,  1'b0);

        for (int i = 0; i < 300; i++) begin
            run_op(1'($urandom), $urandom, 3'($urandom), 5'($urandom), 4'($urandom),
                   ($urandom % 3) == 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule